// File: doc/BRIEF.md
# Intraword Data-Background Sequence Generator

This block drives a memory self-test engine through the data backgrounds and operation codes needed to expose coupling faults between cells that share one memory word. The word is split into bit pairs at a distance that depends on the current level. At level k, a bit belongs to the "even" group when floor(i / 2^k) is even, and to the "odd" group otherwise. A 2-bit pair pattern is then spread across the whole word, so every such pair of bits sees each of the four joint states.

Within a level the generator walks a fixed cycle of eight pair patterns. Each step in the cycle changes exactly one bit of the pair, so two bits never flip at once. Each background carries a short, fixed run of write and read operations, which gives 28 operations per level. There are log2(WIDTH) levels. A consumer pulses a start input, reads the current step from the outputs, and pulses an advance input to move on. The consumer is the part that generates addresses and compares read data. The last step is flagged, and the generator parks there until it is restarted.

Top module: `intraword_bg_gen`

## Requirements
- R1: After reset, and until the first start, valid_o is 0, last_o is 0, bg_o is all zeros and op_o is 2'b00 (none). An idle generator always shows these values.
- R2: A start pulse makes the next cycle present level 0, first step: valid_o=1, op_o write, and the pair pattern 01 (even-group bits 1, odd-group bits 0).
- R3: Within a level, the pair pattern (odd-group bit, even-group bit) goes through 01, 11, 10, 00, 10, 11, 01, 00 in that order.
- R4: At level k, bg_o bit i equals the even-group bit of the pattern when floor(i/2^k) is even, and the odd-group bit otherwise. For WIDTH=8 the first pattern gives 0x55, 0x33 and 0x0F at levels 0, 1 and 2.
- R5: The op_o codes are 01 write, 10 read (sensitizing, data not compared) and 11 read-expect (compare against bg_o). The first four backgrounds of a level carry write, read-expect, write, read, read-expect. The last four carry write, read-expect. This gives 28 steps per level.
- R6: level_o counts 0 up to log2(WIDTH)-1. A level begins only after the previous level's 28 steps.
- R7: last_o is 1 exactly on the final step of the final level.
- R8: While last_o is 1, adv_i has no effect: all outputs hold until start_i.
- R9: With adv_i low the outputs hold. adv_i while idle leaves the generator idle.
- R10: start_i at any time, even together with adv_i, restarts at level 0, step 0.
- R11: Between consecutive steps the pair pattern changes in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart the sequence from level 0, step 0 |
| adv_i | input | 1 | Consume the current step and move to the next |
| valid_o | output | 1 | A step is being presented |
| op_o | output | 2 | Operation code: 00 none, 01 write, 10 read, 11 read-expect |
| bg_o | output | WIDTH | Expanded data background word |
| level_o | output | max(1,clog2(log2 WIDTH)) | Current pairing level |
| last_o | output | 1 | Final step of the final level |

## Verification
The bench walks every step of every level against a table of pair patterns and op codes, with the word expansion computed on its own side. A wrong level mask would show up as a wrong bg_o at levels 1 and 2. A miscounted run of operations would put a write where a read-expect belongs. The bench stalls mid-level to catch a generator that steps without adv_i. It pushes adv_i at the final step, where a generator that wraps would drop last_o or leave level 2. It restarts both mid-sequence and from the parked final step, with adv_i high at the same time, to catch a design that gives advance priority over restart.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RDEXP = 2'b11
    } dbs_op_e;

    localparam int unsigned NUM_BG    = 8;
    localparam int unsigned BG_IDX_W  = 3;
    localparam int unsigned LONG_BG   = 4;
    localparam int unsigned LONG_OPS  = 5;
    localparam int unsigned SHORT_OPS = 2;
    localparam int unsigned POS_W     = 3;

    // pair pattern {odd-group bit, even-group bit} for each background slot
    function automatic logic [1:0] bg_pattern(input logic [BG_IDX_W-1:0] idx);
        logic [1:0] p;
        case (idx)
            3'd0:    p = 2'b01;
            3'd1:    p = 2'b11;
            3'd2:    p = 2'b10;
            3'd3:    p = 2'b00;
            3'd4:    p = 2'b10;
            3'd5:    p = 2'b11;
            3'd6:    p = 2'b01;
            default: p = 2'b00;
        endcase
        return p;
    endfunction

    function automatic dbs_op_e op_at(input logic long_bg, input logic [POS_W-1:0] pos);
        dbs_op_e o;
        if (long_bg) begin
            case (pos)
                3'd0:    o = OP_WRITE;
                3'd1:    o = OP_RDEXP;
                3'd2:    o = OP_WRITE;
                3'd3:    o = OP_READ;
                default: o = OP_RDEXP;
            endcase
        end else begin
            o = (pos == 3'd0) ? OP_WRITE : OP_RDEXP;
        end
        return o;
    endfunction

endpackage

// File: rtl/dbs_step_ctrl.sv
`timescale 1ns/1ps
module dbs_step_ctrl
    import dbs_pkg::*;
#(
    parameter int unsigned LEVELS = 3,
    parameter int unsigned LVW    = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                adv_i,
    output logic                valid_o,
    output logic [LVW-1:0]      level_o,
    output logic [BG_IDX_W-1:0] bg_idx_o,
    output logic [POS_W-1:0]    pos_o,
    output logic                last_o
);

    typedef struct packed {
        logic                valid;
        logic [LVW-1:0]      level;
        logic [BG_IDX_W-1:0] bg;
        logic [POS_W-1:0]    pos;
    } state_t;

    state_t state_d, state_q;
    logic   is_long;
    logic   [POS_W-1:0] pos_max;
    logic   last_d;

    always_comb begin
        state_d = state_q;
        is_long = (state_q.bg < BG_IDX_W'(LONG_BG));
        pos_max = is_long ? POS_W'(LONG_OPS - 1) : POS_W'(SHORT_OPS - 1);
        last_d  = state_q.valid
                  && (state_q.level == LVW'(LEVELS - 1))
                  && (state_q.bg == BG_IDX_W'(NUM_BG - 1))
                  && (state_q.pos == pos_max);
        if (start_i) begin
            state_d.valid = 1'b1;
            state_d.level = '0;
            state_d.bg    = '0;
            state_d.pos   = '0;
        end else if (state_q.valid && adv_i && !last_d) begin
            if (state_q.pos == pos_max) begin
                state_d.pos = '0;
                if (state_q.bg == BG_IDX_W'(NUM_BG - 1)) begin
                    state_d.bg    = '0;
                    state_d.level = state_q.level + 1'b1;
                end else begin
                    state_d.bg = state_q.bg + 1'b1;
                end
            end else begin
                state_d.pos = state_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o  = state_q.valid;
    assign level_o  = state_q.level;
    assign bg_idx_o = state_q.bg;
    assign pos_o    = state_q.pos;
    assign last_o   = last_d;

endmodule

// File: rtl/dbs_op_decode.sv
`timescale 1ns/1ps
module dbs_op_decode
    import dbs_pkg::*;
(
    input  logic                valid_i,
    input  logic [BG_IDX_W-1:0] bg_idx_i,
    input  logic [POS_W-1:0]    pos_i,
    output logic [1:0]          op_o,
    output logic [1:0]          pat_o
);

    dbs_op_e op_sel;

    always_comb begin
        op_sel = op_at(bg_idx_i < BG_IDX_W'(LONG_BG), pos_i);
        if (valid_i) begin
            op_o  = op_sel;
            pat_o = bg_pattern(bg_idx_i);
        end else begin
            op_o  = OP_NONE;
            pat_o = 2'b00;
        end
    end

endmodule

// File: rtl/dbs_bg_expand.sv
`timescale 1ns/1ps
module dbs_bg_expand #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned LEVELS = 3,
    parameter int unsigned LVW    = 2
) (
    input  logic [1:0]       pat_i,
    input  logic [LVW-1:0]   level_i,
    output logic [WIDTH-1:0] word_o
);

    // per level: 1 marks the odd group of each pair
    logic [WIDTH-1:0] odd_mask [LEVELS];
    logic [WIDTH-1:0] sel_mask;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign odd_mask[k][i] = (((i >> k) & 1) != 0);
        end
    end

    always_comb begin
        sel_mask = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (level_i == LVW'(k)) sel_mask = odd_mask[k];
        end
        word_o = (sel_mask & {WIDTH{pat_i[1]}}) | (~sel_mask & {WIDTH{pat_i[0]}});
    end

endmodule

// File: rtl/intraword_bg_gen.sv
`timescale 1ns/1ps
module intraword_bg_gen
    import dbs_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned LEVELS = $clog2(WIDTH),
    localparam int unsigned LVW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             adv_i,
    output logic             valid_o,
    output logic [1:0]       op_o,
    output logic [WIDTH-1:0] bg_o,
    output logic [LVW-1:0]   level_o,
    output logic             last_o
);

    logic [BG_IDX_W-1:0] bg_idx_w;
    logic [POS_W-1:0]    pos_w;
    logic [1:0]          pat_w;

    dbs_step_ctrl #(.LEVELS(LEVELS), .LVW(LVW)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .adv_i    (adv_i),
        .valid_o  (valid_o),
        .level_o  (level_o),
        .bg_idx_o (bg_idx_w),
        .pos_o    (pos_w),
        .last_o   (last_o)
    );

    dbs_op_decode u_dec (
        .valid_i  (valid_o),
        .bg_idx_i (bg_idx_w),
        .pos_i    (pos_w),
        .op_o     (op_o),
        .pat_o    (pat_w)
    );

    dbs_bg_expand #(.WIDTH(WIDTH), .LEVELS(LEVELS), .LVW(LVW)) u_exp (
        .pat_i   (pat_w),
        .level_i (level_o),
        .word_o  (bg_o)
    );

endmodule

// File: rtl/intraword_bg_gen_chk.sv
`timescale 1ns/1ps
module intraword_bg_gen_chk #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned LEVELS = $clog2(WIDTH),
    localparam int unsigned LVW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             adv_i,
    input logic             valid_o,
    input logic [1:0]       op_o,
    input logic [WIDTH-1:0] bg_o,
    input logic [LVW-1:0]   level_o,
    input logic             last_o,
    input logic [1:0]       pat_w
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (bg_o == '0 && op_o == 2'b00 && !last_o));

    // R5
    write_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && adv_i && !start_i && !last_o && op_o == 2'b01)
        |=> (op_o[1] && bg_o == $past(bg_o)));

    // R8
    last_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (last_o && !start_i) |=> (last_o && $stable(bg_o) && $stable(op_o) && $stable(level_o)));

    // R11
    single_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && adv_i && !start_i && !last_o) |=> ($countones(pat_w ^ $past(pat_w)) <= 1));

    // R4
    balanced_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ($countones(bg_o) == 0 || $countones(bg_o) == WIDTH / 2
                     || $countones(bg_o) == WIDTH));

    // R10
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (valid_o && level_o == '0 && op_o == 2'b01 && pat_w == 2'b01));

    // R9
    stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !start_i) |=> ($stable(bg_o) && $stable(op_o) && $stable(level_o) && $stable(valid_o)));

    // R7
    last_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |-> (valid_o && level_o == LVW'(LEVELS - 1) && op_o == 2'b11));

endmodule

bind intraword_bg_gen intraword_bg_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .adv_i   (adv_i),
    .valid_o (valid_o),
    .op_o    (op_o),
    .bg_o    (bg_o),
    .level_o (level_o),
    .last_o  (last_o),
    .pat_w   (pat_w)
);

// File: tb/intraword_bg_gen_bench.sv
`timescale 1ns/1ps
module intraword_bg_gen_bench;

    localparam int unsigned WIDTH  = 8;
    localparam int unsigned LEVELS = $clog2(WIDTH);
    localparam int unsigned LVW    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int unsigned STEPS  = 28;

    // {pair pattern (odd,even), op code} per step of one level
    localparam logic [3:0] VEC [STEPS] = '{
        4'b0101, 4'b0111, 4'b0101, 4'b0110, 4'b0111,
        4'b1101, 4'b1111, 4'b1101, 4'b1110, 4'b1111,
        4'b1001, 4'b1011, 4'b1001, 4'b1010, 4'b1011,
        4'b0001, 4'b0011, 4'b0001, 4'b0010, 4'b0011,
        4'b1001, 4'b1011,
        4'b1101, 4'b1111,
        4'b0101, 4'b0111,
        4'b0001, 4'b0011
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             adv = 1'b0;
    logic             valid;
    logic [1:0]       op;
    logic [WIDTH-1:0] bg;
    logic [LVW-1:0]   level;
    logic             last;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    intraword_bg_gen #(.WIDTH(WIDTH)) u_intraword_bg_gen (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .adv_i   (adv),
        .valid_o (valid),
        .op_o    (op),
        .bg_o    (bg),
        .level_o (level),
        .last_o  (last)
    );

    function automatic logic [WIDTH-1:0] exp_word(input logic [1:0] p, input int lvl);
        logic [WIDTH-1:0] w;
        for (int i = 0; i < WIDTH; i++) w[i] = (((i >> lvl) & 1) != 0) ? p[1] : p[0];
        return w;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input logic a, input logic s);
        adv = a;
        start = s;
        @(posedge clk);
        #1;
        adv = 1'b0;
        start = 1'b0;
    endtask

    task automatic chk_step(input string req, input int lvl, input int s);
        chk(req, "bg", 32'(bg), 32'(exp_word(VEC[s][3:2], lvl)));
        chk(req, "op", 32'(op), 32'(VEC[s][1:0]));
        chk(req, "level", 32'(level), 32'(lvl));
        chk(req, "valid", 32'(valid), 32'd1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "valid", 32'(valid), 32'd0);
        chk("R1", "last", 32'(last), 32'd0);
        chk("R1", "bg", 32'(bg), 32'd0);
        chk("R1", "op", 32'(op), 32'd0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0);
        // R9 advance while idle is ignored
        cycle(1'b1, 1'b0);
        chk("R9", "idle valid", 32'(valid), 32'd0);
        chk("R1", "idle bg", 32'(bg), 32'd0);

        // R2 start
        cycle(1'b0, 1'b1);
        chk("R2", "first bg", 32'(bg), 32'h55);
        chk("R2", "first op", 32'(op), 32'd1);

        // R3 R4 R5 R6 R7 full walk
        for (int lvl = 0; lvl < int'(LEVELS); lvl++) begin
            for (int s = 0; s < int'(STEPS); s++) begin
                chk_step("R3/R4/R5/R6", lvl, s);
                chk("R7", "last", 32'(last), 32'((lvl == int'(LEVELS) - 1) && (s == int'(STEPS) - 1)));
                if ((s % 7) == 3) begin
                    cycle(1'b0, 1'b0);
                    chk_step("R9", lvl, s);
                end
                if (!((lvl == int'(LEVELS) - 1) && (s == int'(STEPS) - 1))) cycle(1'b1, 1'b0);
            end
        end

        // R4 explicit level masks
        chk("R4", "level2 final word", 32'(bg), 32'(exp_word(2'b00, 2)));

        // R8 advance at final step is ignored
        for (int n = 0; n < 3; n++) begin
            cycle(1'b1, 1'b0);
            chk("R8", "last held", 32'(last), 32'd1);
            chk("R8", "level held", 32'(level), 32'(LEVELS - 1));
            chk("R8", "op held", 32'(op), 32'd3);
        end

        // R10 restart from parked end with adv high
        cycle(1'b1, 1'b1);
        chk_step("R10", 0, 0);
        chk("R10", "last cleared", 32'(last), 32'd0);

        // walk into level 1 then restart mid-sequence
        for (int n = 0; n < int'(STEPS) + 2; n++) cycle(1'b1, 1'b0);
        chk_step("R6", 1, 2);
        chk("R4", "level1 word", 32'(bg), 32'h33);
        cycle(1'b1, 1'b1);
        chk_step("R10", 0, 0);
        chk("R2", "restart bg", 32'(bg), 32'h55);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule